// File: doc/BRIEF.md
# Tiled Matrix Multiply-Accumulate Engine

The engine forms D = A·B + C for signed fixed-point matrices held in three read-only local memories, and writes D to a fourth memory. A is M×K, B is K×N, and C and D are M×N. All four matrices are stored row-major: element (r, c) of a matrix with `cols` columns sits at address r·cols + c. One multiply-accumulate unit runs one product per clock, so a full run takes roughly M·N·K cycles.

The output is built one square tile at a time. For a given output tile the engine walks every K tile and accumulates the products into a small tile accumulator. The first product for each slot overwrites the value left from the previous tile. After the last K tile has been added, the engine makes a second pass over the tile. In that pass it reads the matching C elements, adds each one exactly once, and writes the sums to D. A start pulse launches a run. The memories answer a read enable with data one cycle later. A one-cycle done pulse marks the end of the run.

Top module: `mmac_tiled_engine`

## Requirements
- R1: One run writes, for every row r and column c, D[r][c] = Σk A[r][k]·B[k][c] + C[r][c]. Addresses are row-major: A at r·K+k, B at k·N+c, C and D at r·N+c. Each memory returns read data in the cycle after its read enable.
- R2: Inputs are 8-bit two's complement and D is 20-bit two's complement. The result is exact with no overflow, even when every input of A and B is -128, or when A is all -128 and B is all 127.
- R3: Each output tile starts from an empty accumulator. No partial sum from an earlier tile or an earlier run reaches a later result.
- R4: Each run makes exactly M·N D writes, one to each D address. Every write address is below M·N.
- R5: Per output tile, all TILE·TILE·K reads of A and B come before the TILE·TILE reads of C for that tile. Before the n-th C read of a run (counting from 0), exactly (n div TILE² + 1)·TILE²·K A reads have occurred. A and B read enables are always high together, and never in the same cycle as the C read enable.
- R6: done is high for exactly one cycle. That cycle directly follows the cycle in which the last D write is presented. It comes M·N·K + M·N + 3 clock edges after the edge that samples start. busy is high from that start edge until done, and is low while done is high.
- R7: A start pulse while busy is high is ignored. It does not change the results, the done timing or the number of done pulses.
- R8: While reset is high, and in the cycle after it falls, busy, done, d_we and all read enables are low. A reset in the middle of a run abandons it, and the next start runs correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| a_re | output | 1 | A read enable |
| a_addr | output | 6 | A read address |
| a_rdata | input | 8 | A read data, one cycle after a_re |
| b_re | output | 1 | B read enable |
| b_addr | output | 6 | B read address |
| b_rdata | input | 8 | B read data, one cycle after b_re |
| c_re | output | 1 | C read enable |
| c_addr | output | 6 | C read address |
| c_rdata | input | 8 | C read data, one cycle after c_re |
| d_we | output | 1 | D write enable |
| d_addr | output | 6 | D write address |
| d_wdata | output | 20 | D write data |

## Verification
The assertions assume that reset is applied before the first start. They also assume that the memories answer every read enable with data exactly one cycle later. The bench models the four memories as registered arrays with exactly that latency. It drives start only as a one-cycle pulse, applied just after a clock edge, and it only exercises extra start pulses while busy is high, as R7 requires. All matrix values stay inside the 8-bit signed range, so the overflow bound of R2 is the only width the bench leans on.

// File: rtl/mmac_pkg.sv
`timescale 1ns/1ps
package mmac_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_MAC, ST_BIAS} seq_state_t;

  // counter width that never collapses to zero bits
  function automatic int cnt_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/mmac_seq.sv
`timescale 1ns/1ps
module mmac_seq import mmac_pkg::*; #(
  parameter int TILE  = 4,
  parameter int DIM_M = 8,
  parameter int DIM_N = 8,
  parameter int DIM_K = 8,
  parameter int AA_W  = 6,
  parameter int BA_W  = 6,
  parameter int CA_W  = 6,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  output logic             a_re,
  output logic [AA_W-1:0]  a_addr,
  output logic             b_re,
  output logic [BA_W-1:0]  b_addr,
  output logic             c_re,
  output logic [CA_W-1:0]  c_addr,
  output logic [IDX_W-1:0] slot,
  output logic             first,
  output logic             last
);
  localparam int NT_M = DIM_M / TILE;
  localparam int NT_N = DIM_N / TILE;
  localparam int NT_K = DIM_K / TILE;
  localparam int EW   = cnt_w(TILE);
  localparam int MW   = cnt_w(NT_M);
  localparam int NW   = cnt_w(NT_N);
  localparam int KW   = cnt_w(NT_K);
  localparam logic [EW-1:0] E_MAX = EW'(TILE - 1);
  localparam logic [MW-1:0] M_MAX = MW'(NT_M - 1);
  localparam logic [NW-1:0] N_MAX = NW'(NT_N - 1);
  localparam logic [KW-1:0] K_MAX = KW'(NT_K - 1);

  seq_state_t st;
  logic [MW-1:0] ti;
  logic [NW-1:0] tj;
  logic [KW-1:0] tk;
  logic [EW-1:0] i, j, k;

  logic tile_end;
  assign tile_end = (i == E_MAX) && (j == E_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      ti     <= '0;
      tj     <= '0;
      tk     <= '0;
      i      <= '0;
      j      <= '0;
      k      <= '0;
      a_re   <= 1'b0;
      b_re   <= 1'b0;
      c_re   <= 1'b0;
      a_addr <= '0;
      b_addr <= '0;
      c_addr <= '0;
      slot   <= '0;
      first  <= 1'b0;
      last   <= 1'b0;
    end else begin
      a_re <= 1'b0;
      b_re <= 1'b0;
      c_re <= 1'b0;
      last <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (go) begin
            st <= ST_MAC;
            ti <= '0;
            tj <= '0;
            tk <= '0;
            i  <= '0;
            j  <= '0;
            k  <= '0;
          end
        end
        ST_MAC: begin
          a_re   <= 1'b1;
          b_re   <= 1'b1;
          a_addr <= AA_W'((int'(ti) * TILE + int'(i)) * DIM_K + int'(tk) * TILE + int'(k));
          b_addr <= BA_W'((int'(tk) * TILE + int'(k)) * DIM_N + int'(tj) * TILE + int'(j));
          slot   <= IDX_W'(int'(i) * TILE + int'(j));
          first  <= (tk == '0) && (k == '0);
          if (k != E_MAX) k <= k + 1'b1;
          else begin
            k <= '0;
            if (j != E_MAX) j <= j + 1'b1;
            else begin
              j <= '0;
              if (i != E_MAX) i <= i + 1'b1;
              else begin
                i <= '0;
                if (tk != K_MAX) tk <= tk + 1'b1;
                else begin
                  tk <= '0;
                  st <= ST_BIAS;
                end
              end
            end
          end
        end
        ST_BIAS: begin
          c_re   <= 1'b1;
          c_addr <= CA_W'((int'(ti) * TILE + int'(i)) * DIM_N + int'(tj) * TILE + int'(j));
          slot   <= IDX_W'(int'(i) * TILE + int'(j));
          first  <= 1'b0;
          last   <= tile_end && (ti == M_MAX) && (tj == N_MAX);
          if (j != E_MAX) j <= j + 1'b1;
          else begin
            j <= '0;
            if (i != E_MAX) i <= i + 1'b1;
            else begin
              i <= '0;
              if (tj != N_MAX) begin
                tj <= tj + 1'b1;
                st <= ST_MAC;
              end else begin
                tj <= '0;
                if (ti != M_MAX) begin
                  ti <= ti + 1'b1;
                  st <= ST_MAC;
                end else begin
                  ti <= '0;
                  st <= ST_IDLE;
                end
              end
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mmac_tile_acc.sv
`timescale 1ns/1ps
module mmac_tile_acc #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 19,
  parameter int SLOTS  = 16,
  parameter int IDX_W  = 4
) (
  input  logic                     clk,
  input  logic                     mac_v,
  input  logic                     first,
  input  logic [IDX_W-1:0]         wr_slot,
  input  logic signed [DATA_W-1:0] a_val,
  input  logic signed [DATA_W-1:0] b_val,
  input  logic [IDX_W-1:0]         rd_slot,
  output logic signed [ACC_W-1:0]  rd_val
);
  localparam int PROD_W = 2 * DATA_W;

  logic signed [ACC_W-1:0]  acc_mem [SLOTS];
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  base;

  assign prod   = a_val * b_val;
  assign base   = first ? '0 : acc_mem[wr_slot];
  assign rd_val = acc_mem[rd_slot];

  always_ff @(posedge clk) begin
    if (mac_v) acc_mem[wr_slot] <= base + ACC_W'(prod);
  end
endmodule

// File: rtl/mmac_bias_out.sv
`timescale 1ns/1ps
module mmac_bias_out #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 19,
  parameter int OUT_W  = 20,
  parameter int DA_W   = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bias_v,
  input  logic                     last,
  input  logic [DA_W-1:0]          addr,
  input  logic signed [ACC_W-1:0]  acc_val,
  input  logic signed [DATA_W-1:0] c_val,
  output logic                     d_we,
  output logic [DA_W-1:0]          d_addr,
  output logic signed [OUT_W-1:0]  d_wdata,
  output logic                     done,
  output logic                     done_set
);
  logic last_q;

  assign done_set = d_we && last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      d_we    <= 1'b0;
      last_q  <= 1'b0;
      done    <= 1'b0;
      d_addr  <= '0;
      d_wdata <= '0;
    end else begin
      d_we   <= bias_v;
      last_q <= bias_v && last;
      done   <= done_set;
      if (bias_v) begin
        d_addr  <= addr;
        d_wdata <= OUT_W'(acc_val) + OUT_W'(c_val);
      end
    end
  end
endmodule

// File: rtl/mmac_tiled_engine.sv
`timescale 1ns/1ps
module mmac_tiled_engine import mmac_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int TILE   = 4,
  parameter int DIM_M  = 8,
  parameter int DIM_N  = 8,
  parameter int DIM_K  = 8,
  localparam int AA_W  = cnt_w(DIM_M * DIM_K),
  localparam int BA_W  = cnt_w(DIM_K * DIM_N),
  localparam int DA_W  = cnt_w(DIM_M * DIM_N),
  localparam int ACC_W = 2 * DATA_W + cnt_w(DIM_K),
  localparam int OUT_W = ACC_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  output logic                     busy,
  output logic                     done,
  output logic                     a_re,
  output logic [AA_W-1:0]          a_addr,
  input  logic signed [DATA_W-1:0] a_rdata,
  output logic                     b_re,
  output logic [BA_W-1:0]          b_addr,
  input  logic signed [DATA_W-1:0] b_rdata,
  output logic                     c_re,
  output logic [DA_W-1:0]          c_addr,
  input  logic signed [DATA_W-1:0] c_rdata,
  output logic                     d_we,
  output logic [DA_W-1:0]          d_addr,
  output logic signed [OUT_W-1:0]  d_wdata
);
  localparam int SLOTS = TILE * TILE;
  localparam int IDX_W = cnt_w(SLOTS);

  logic             go, done_set;
  logic [IDX_W-1:0] slot1, slot2;
  logic             first1, first2, last1, last2;
  logic             mac_v2, bias_v2;
  logic [DA_W-1:0]  addr2;
  logic signed [ACC_W-1:0] acc_val;

  assign go = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) busy <= 1'b0;
    else if (go) busy <= 1'b1;
    else if (done_set) busy <= 1'b0;
  end

  mmac_seq #(
    .TILE(TILE), .DIM_M(DIM_M), .DIM_N(DIM_N), .DIM_K(DIM_K),
    .AA_W(AA_W), .BA_W(BA_W), .CA_W(DA_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst(rst), .go(go),
    .a_re(a_re), .a_addr(a_addr), .b_re(b_re), .b_addr(b_addr),
    .c_re(c_re), .c_addr(c_addr),
    .slot(slot1), .first(first1), .last(last1)
  );

  // align tags with the memory read latency
  always_ff @(posedge clk) begin
    if (rst) begin
      mac_v2  <= 1'b0;
      bias_v2 <= 1'b0;
      slot2   <= '0;
      first2  <= 1'b0;
      last2   <= 1'b0;
      addr2   <= '0;
    end else begin
      mac_v2  <= a_re;
      bias_v2 <= c_re;
      slot2   <= slot1;
      first2  <= first1;
      last2   <= last1;
      addr2   <= c_addr;
    end
  end

  mmac_tile_acc #(
    .DATA_W(DATA_W), .ACC_W(ACC_W), .SLOTS(SLOTS), .IDX_W(IDX_W)
  ) u_acc (
    .clk(clk), .mac_v(mac_v2), .first(first2), .wr_slot(slot2),
    .a_val(a_rdata), .b_val(b_rdata),
    .rd_slot(slot2), .rd_val(acc_val)
  );

  mmac_bias_out #(
    .DATA_W(DATA_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .DA_W(DA_W)
  ) u_out (
    .clk(clk), .rst(rst), .bias_v(bias_v2), .last(last2), .addr(addr2),
    .acc_val(acc_val), .c_val(c_rdata),
    .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata),
    .done(done), .done_set(done_set)
  );
endmodule

// File: rtl/mmac_chk.sv
`timescale 1ns/1ps
module mmac_chk #(
  parameter int MN   = 64,
  parameter int DA_W = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            a_re,
  input logic            b_re,
  input logic            c_re,
  input logic            d_we,
  input logic [DA_W-1:0] d_addr
);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_after_write_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(d_we) && !d_we));
  assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_start_taken_R6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (start && busy && !done) |=> busy);
  assert_addr_range_R4: assert property (@(posedge clk) disable iff (rst)
    d_we |-> (int'(d_addr) < MN));
  assert_write_in_run_R4: assert property (@(posedge clk) disable iff (rst)
    d_we |-> busy);
  assert_ab_paired_R5: assert property (@(posedge clk) disable iff (rst)
    a_re == b_re);
  assert_phase_excl_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({a_re, c_re}));
  assert_quiet_after_reset_R8: assert property (@(posedge clk)
    $fell(rst) |-> !(busy || done || d_we || a_re || c_re));
endmodule

bind mmac_tiled_engine mmac_chk #(.MN(DIM_M * DIM_N), .DA_W(DA_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .a_re(a_re), .b_re(b_re), .c_re(c_re), .d_we(d_we), .d_addr(d_addr)
);

// File: tb/tb_mmac_tiled_engine.sv
`timescale 1ns/1ps
module tb_mmac_tiled_engine;
  localparam int T  = 4;
  localparam int M  = 8;
  localparam int N  = 8;
  localparam int K  = 8;
  localparam int OW = 20;
  localparam int RUN_EDGES = M * N * K + M * N + 3;
  localparam int NCASE = 6;
  // stimulus table: {pattern mode, seed}
  localparam int CASES [NCASE][2] = '{'{0, 1}, '{1, 3}, '{2, 0}, '{3, 0}, '{4, 5}, '{1, 9}};

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic busy, done, a_re, b_re, c_re, d_we;
  logic [5:0] a_addr, b_addr, c_addr, d_addr;
  logic signed [7:0] a_rdata, b_rdata, c_rdata;
  logic signed [OW-1:0] d_wdata;

  logic signed [7:0]    amem [M*K];
  logic signed [7:0]    bmem [K*N];
  logic signed [7:0]    cmem [M*N];
  logic signed [OW-1:0] dmem [M*N];
  int exp_d [M*N];

  int n_checks = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  mmac_tiled_engine dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .a_re(a_re), .a_addr(a_addr), .a_rdata(a_rdata),
    .b_re(b_re), .b_addr(b_addr), .b_rdata(b_rdata),
    .c_re(c_re), .c_addr(c_addr), .c_rdata(c_rdata),
    .d_we(d_we), .d_addr(d_addr), .d_wdata(d_wdata)
  );

  always_ff @(posedge clk) begin
    if (a_re) a_rdata <= amem[a_addr];
    if (b_re) b_rdata <= bmem[b_addr];
    if (c_re) c_rdata <= cmem[c_addr];
    if (d_we) dmem[d_addr] <= d_wdata;
  end

  // port monitor, sampled on the falling edge
  int cyc = 0, t_go = 0, t_done = 0;
  int n_a = 0, n_b = 0, n_c = 0, n_w = 0, n_done = 0;
  int order_err = 0, timing_err = 0, dup_err = 0;
  int wr_cnt [M*N];
  logic prev_we = 1'b0, prev_done = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (start && !busy && !rst) begin
      t_go = cyc; n_a = 0; n_b = 0; n_c = 0; n_w = 0; n_done = 0;
      order_err = 0; timing_err = 0; dup_err = 0;
      for (int q = 0; q < M*N; q++) wr_cnt[q] = 0;
    end
    if (c_re) begin
      if (n_a != (n_c / (T*T) + 1) * T * T * K) order_err++;
      n_c++;
    end
    if (a_re) n_a++;
    if (b_re) n_b++;
    if (d_we) begin
      n_w++;
      if (int'(d_addr) < M*N) begin
        if (wr_cnt[d_addr] != 0) dup_err++;
        wr_cnt[d_addr]++;
      end else dup_err++;
    end
    if (done) begin
      n_done++;
      t_done = cyc;
      if (!prev_we || d_we || prev_done || busy) timing_err++;
    end
    prev_we   = d_we;
    prev_done = done;
  end

  task automatic check(input string req, input int act, input int expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int gen(input int mode, input int sel, input int r, input int c, input int seed);
    case (mode)
      0: return (sel == 0) ? ((r == c) ? 1 : 0) :
                (sel == 1) ? (((r * 8 + c) * 3 + seed) % 256) - 128 : (r - c) * seed;
      2: return (sel == 2) ? 127 : -128;
      3: return (sel == 0) ? -128 : (sel == 1) ? 127 : -128;
      4: return (sel == 0) ? 0 : (((r * 19 + c * 5 + sel + seed) * 41) % 256) - 128;
      default: return (((r * 37 + c * 11 + sel * 53 + seed * 29) * 97) % 256) - 128;
    endcase
  endfunction

  task automatic load(input int mode, input int seed);
    for (int r = 0; r < M; r++) for (int k = 0; k < K; k++) amem[r*K+k] = 8'(gen(mode, 0, r, k, seed));
    for (int k = 0; k < K; k++) for (int c = 0; c < N; c++) bmem[k*N+c] = 8'(gen(mode, 1, k, c, seed));
    for (int r = 0; r < M; r++) for (int c = 0; c < N; c++) begin
      int s;
      cmem[r*N+c] = 8'(gen(mode, 2, r, c, seed));
      s = int'(cmem[r*N+c]);
      for (int k = 0; k < K; k++) s += int'(amem[r*K+k]) * int'(bmem[k*N+c]);
      exp_d[r*N+c] = s;
      dmem[r*N+c] = '0;
    end
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int w = 0; w < 3000; w++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic verify_run(input string tag);
    int bad = 0, first_bad = -1;
    for (int q = 0; q < M*N; q++)
      if (int'(dmem[q]) != exp_d[q]) begin bad++; if (first_bad < 0) first_bad = q; end
    if (first_bad >= 0)
      check({tag, " R1 R2 R3 D value"}, int'(dmem[first_bad]), exp_d[first_bad]);
    else check({tag, " R1 R2 R3 D value"}, 0, 0);
    check({tag, " R4 write count"}, n_w, M*N);
    check({tag, " R4 one write per address"}, dup_err, 0);
    check({tag, " R5 read ordering"}, order_err, 0);
    check({tag, " R5 A reads"}, n_a, M*N*K);
    check({tag, " R5 B reads"}, n_b, M*N*K);
    check({tag, " R6 done pulse shape"}, timing_err + n_done, 1);
    check({tag, " R6 done latency"}, t_done - t_go, RUN_EDGES + 1);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    bit ok;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R8 idle in reset", {busy, done, d_we, a_re, b_re, c_re}, 0);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R8 idle after reset", {busy, done, d_we, a_re, b_re, c_re}, 0);

    // table-driven runs
    for (int t = 0; t < NCASE; t++) begin
      load(CASES[t][0], CASES[t][1]);
      pulse_start();
      wait_done(ok);
      check($sformatf("case%0d R6 done seen", t), int'(ok), 1);
      verify_run($sformatf("case%0d", t));
    end

    // R7: start pulses while busy are ignored
    load(1, 21);
    pulse_start();
    repeat (100) @(posedge clk);
    #1 start = 1'b1; @(posedge clk); #1 start = 1'b0;
    repeat (300) @(posedge clk);
    #1 start = 1'b1; @(posedge clk); #1 start = 1'b0;
    wait_done(ok);
    check("R7 done seen", int'(ok), 1);
    verify_run("R7 restart-ignored");
    check("R7 idle after run", int'(busy), 0);

    // R8: reset mid-run then clean run
    load(2, 0);
    pulse_start();
    repeat (200) @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 idle in mid-run reset", {busy, done, d_we, a_re, b_re, c_re}, 0);
    #1 rst = 1'b0;
    load(1, 33);
    pulse_start();
    wait_done(ok);
    check("R8 done after reset", int'(ok), 1);
    verify_run("R8 post-reset");

    summary();
    $finish;
  end
endmodule